// File: doc/BRIEF.md
# Six-Opcode Programmable Processor Core

This block is a compact programmable processor made of a controller state machine and a datapath. The datapath holds a register file of sixteen 16-bit words with two read ports and one write port, a data memory of 256 words of 16 bits, and an arithmetic unit that can pass an operand through, add or subtract. A program counter addresses an instruction memory of 16-bit words. Every instruction is handled in three steps: fetch into the instruction register, decode, and one execute step chosen by the opcode.

The instruction set has six operations: memory-to-register load, register-to-memory store, add, subtract, load of an 8-bit constant, and a conditional relative branch taken when a register is zero. While reset is held, a write port fills either memory. A read port shows any data memory word, so results can be checked.

The controller states are Init, Fetch, Decode and seven execute states: Load, Store, Add, LoadConst, Sub, JumpZero and Idle. Idle covers the undefined opcodes. The transitions are:
- Init to Fetch.
- Fetch to Decode.
- Decode to the execute state selected by the opcode.
- Every execute state back to Fetch.

Top module: `proc6_core`

## Requirements
- R1: While `rst` is high, the controller sits in Init, `fetch_out` is 0 and `pc_out` is 0. On the first rising edge after `rst` falls, the controller enters Fetch with `pc_out` = 0. Raising `rst` during a run returns the core to this state at the next edge.
- R2: Fetch loads the instruction register from the instruction memory at PC and increments PC. Every instruction takes exactly three cycles (fetch, decode, execute). Counting rising edges after `rst` falls, the execute edge of instruction k is edge 4 + 3k.
- R3: Opcode bits [15:12] = 0000 loads RF[ra] from D[d]. Opcode 0001 stores RF[ra] into D[d]. Here ra = IR[11:8] and d = IR[7:0].
- R4: Opcode 0010 writes RF[ra] = RF[rb] + RF[rc], and opcode 0100 writes RF[ra] = RF[rb] - RF[rc]. Here rb = IR[7:4] and rc = IR[3:0]. Both results wrap modulo 2^16.
- R5: Opcode 0011 writes RF[ra] = IR[7:0], zero-extended to 16 bits.
- R6: Opcode 0101, when RF[ra] is zero, sets PC to (address of the branch + 1) + signext(IR[7:0]) - 1. An offset of 0 therefore re-executes the branch itself, and negative offsets jump backwards.
- R7: Opcode 0101 with RF[ra] nonzero leaves PC as set by the fetch, so execution continues with the next instruction.
- R8: Opcodes 0110 to 1111 write neither the register file nor the data memory, and execution continues with the next instruction.
- R9: With `ld_en` high, a rising edge writes `ld_data` at `ld_addr`. The target is the data memory when `ld_dmem` = 1 and the instruction memory when `ld_dmem` = 0. `peek_data` always shows D[`peek_addr`] combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, forces Init |
| ld_en | input | 1 | Memory preload write enable |
| ld_dmem | input | 1 | Preload target: 1 data memory, 0 instruction memory |
| ld_addr | input | 8 | Preload word address |
| ld_data | input | 16 | Preload write data |
| peek_addr | input | 8 | Data memory observation address |
| peek_data | output | 16 | Data memory word at peek_addr |
| pc_out | output | 16 | Program counter |
| fetch_out | output | 1 | High while the controller is in Fetch |

## Verification
Results land on a fixed schedule: `fetch_out` rises one edge after reset release, PC reaches 1 on the second edge, and the store that is the fourth instruction lands on edge 13. The bench counts edges from the release and samples at the falling edge. It confirms the destination word still holds its old value after edge 12 and the new value after edge 13. For the programs that contain branches and loops, it waits well past the last store before reading the result through the peek port. Each program then ends by branching to itself, so the memory contents stay fixed while they are read.

// File: rtl/proc6_pkg.sv
package proc6_pkg;

    localparam logic [3:0] OPC_LOAD  = 4'b0000;
    localparam logic [3:0] OPC_STORE = 4'b0001;
    localparam logic [3:0] OPC_ADD   = 4'b0010;
    localparam logic [3:0] OPC_LDC   = 4'b0011;
    localparam logic [3:0] OPC_SUB   = 4'b0100;
    localparam logic [3:0] OPC_JZ    = 4'b0101;

    typedef enum logic [3:0] {
        ST_INIT, ST_FETCH, ST_DECODE,
        ST_LOAD, ST_STORE, ST_ADD, ST_LDC, ST_SUB, ST_JZ, ST_IDLE
    } ctl_state_e;

    typedef enum logic [1:0] {
        ALU_PASS = 2'b00,
        ALU_ADD  = 2'b01,
        ALU_SUB  = 2'b10
    } alu_op_e;

    typedef enum logic [1:0] {
        WSRC_ALU = 2'b00,
        WSRC_MEM = 2'b01,
        WSRC_IMM = 2'b10
    } wsrc_e;

    typedef struct packed {
        logic    pc_clr;
        logic    pc_inc;
        logic    pc_jmp;
        logic    ir_ld;
        logic    rf_we;
        logic    dm_we;
        logic    rp_use_rb;
        wsrc_e   wsrc;
        alu_op_e alu;
    } ctl_t;

endpackage

// File: rtl/proc6_regfile.sv
module proc6_regfile #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] rp_addr,
    output logic [DATA_W-1:0] rp_data,
    input  logic [ADDR_W-1:0] rq_addr,
    output logic [DATA_W-1:0] rq_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rp_data = words[rp_addr];
    assign rq_data = words[rq_addr];
endmodule

// File: rtl/proc6_alu.sv
module proc6_alu
    import proc6_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/proc6_ctrl.sv
module proc6_ctrl
    import proc6_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] opcode,
    input  logic       rp_zero,
    output ctl_state_e state,
    output ctl_t       ctl
);
    ctl_state_e state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_INIT;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = ST_FETCH;
        unique case (state)
            ST_INIT:   state_nx = ST_FETCH;
            ST_FETCH:  state_nx = ST_DECODE;
            ST_DECODE: begin
                unique case (opcode)
                    OPC_LOAD:  state_nx = ST_LOAD;
                    OPC_STORE: state_nx = ST_STORE;
                    OPC_ADD:   state_nx = ST_ADD;
                    OPC_LDC:   state_nx = ST_LDC;
                    OPC_SUB:   state_nx = ST_SUB;
                    OPC_JZ:    state_nx = ST_JZ;
                    default:   state_nx = ST_IDLE;
                endcase
            end
            default:   state_nx = ST_FETCH;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (state)
            ST_INIT:  ctl.pc_clr = 1'b1;
            ST_FETCH: begin
                ctl.pc_inc = 1'b1;
                ctl.ir_ld  = 1'b1;
            end
            ST_LOAD: begin
                ctl.rf_we = 1'b1;
                ctl.wsrc  = WSRC_MEM;
            end
            ST_STORE: ctl.dm_we = 1'b1;
            ST_ADD: begin
                ctl.rf_we     = 1'b1;
                ctl.rp_use_rb = 1'b1;
                ctl.alu       = ALU_ADD;
                ctl.wsrc      = WSRC_ALU;
            end
            ST_SUB: begin
                ctl.rf_we     = 1'b1;
                ctl.rp_use_rb = 1'b1;
                ctl.alu       = ALU_SUB;
                ctl.wsrc      = WSRC_ALU;
            end
            ST_LDC: begin
                ctl.rf_we = 1'b1;
                ctl.wsrc  = WSRC_IMM;
            end
            ST_JZ:    ctl.pc_jmp = rp_zero;
            default:  ctl = '0;
        endcase
    end

    // R2: decode always hands over to an execute state
    a_r2_decode_to_exec: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE) |=> !(state inside {ST_INIT, ST_FETCH, ST_DECODE}));

    // R2: every execute state returns to fetch
    a_r2_exec_to_fetch: assert property (@(posedge clk) disable iff (rst)
        !(state inside {ST_INIT, ST_FETCH, ST_DECODE}) |=> (state == ST_FETCH));

    // R8: undefined opcodes write nothing
    a_r8_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !(ctl.rf_we || ctl.dm_we));
endmodule

// File: rtl/proc6_core.sv
module proc6_core
    import proc6_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int RF_AW   = 4,
    parameter int IMEM_AW = 8,
    parameter int DMEM_AW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_en,
    input  logic               ld_dmem,
    input  logic [7:0]         ld_addr,
    input  logic [15:0]        ld_data,
    input  logic [7:0]         peek_addr,
    output logic [15:0]        peek_data,
    output logic [15:0]        pc_out,
    output logic               fetch_out
);
    localparam int IMEM_DEPTH = 1 << IMEM_AW;
    localparam int DMEM_DEPTH = 1 << DMEM_AW;
    localparam int PC_W       = 16;
    localparam int FLD_W      = 8;

    ctl_state_e        state;
    ctl_t              ctl;
    logic [PC_W-1:0]   pc;
    logic [15:0]       ir;
    logic [15:0]       imem [IMEM_DEPTH];
    logic [DATA_W-1:0] dmem [DMEM_DEPTH];

    logic [3:0]        ra, rb, rc;
    logic [FLD_W-1:0]  fld;
    logic [RF_AW-1:0]  rp_addr;
    logic [DATA_W-1:0] rp_data, rq_data, alu_y, rf_wdata, dm_rdata;
    logic [PC_W-1:0]   jump_off, jump_pc;
    logic              rp_zero;

    assign ra  = ir[11:8];
    assign rb  = ir[7:4];
    assign rc  = ir[3:0];
    assign fld = ir[7:0];

    proc6_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .opcode  (ir[15:12]),
        .rp_zero (rp_zero),
        .state   (state),
        .ctl     (ctl)
    );

    // program counter and instruction register
    assign jump_off = {{(PC_W-FLD_W){fld[FLD_W-1]}}, fld};
    assign jump_pc  = pc + jump_off - PC_W'(1);

    always_ff @(posedge clk) begin
        if (rst || ctl.pc_clr) begin
            pc <= '0;
        end else if (ctl.pc_inc) begin
            pc <= pc + PC_W'(1);
        end else if (ctl.pc_jmp) begin
            pc <= jump_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (ctl.ir_ld) begin
            ir <= imem[pc[IMEM_AW-1:0]];
        end
    end

    // memories
    always_ff @(posedge clk) begin
        if (ld_en && !ld_dmem) begin
            imem[ld_addr[IMEM_AW-1:0]] <= ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (ld_en && ld_dmem) begin
            dmem[ld_addr[DMEM_AW-1:0]] <= ld_data[DATA_W-1:0];
        end else if (ctl.dm_we) begin
            dmem[fld[DMEM_AW-1:0]] <= rp_data;
        end
    end

    assign dm_rdata  = dmem[fld[DMEM_AW-1:0]];
    assign peek_data = dmem[peek_addr[DMEM_AW-1:0]];

    // register file, ALU and write-data selection
    assign rp_addr = ctl.rp_use_rb ? rb : ra;
    assign rp_zero = ~|rp_data;

    proc6_regfile #(.DATA_W(DATA_W), .ADDR_W(RF_AW)) u_rf (
        .clk     (clk),
        .we      (ctl.rf_we),
        .waddr   (ra),
        .wdata   (rf_wdata),
        .rp_addr (rp_addr),
        .rp_data (rp_data),
        .rq_addr (rc),
        .rq_data (rq_data)
    );

    proc6_alu #(.DATA_W(DATA_W)) u_alu (
        .op (ctl.alu),
        .a  (rp_data),
        .b  (rq_data),
        .y  (alu_y)
    );

    always_comb begin
        unique case (ctl.wsrc)
            WSRC_MEM: rf_wdata = dm_rdata;
            WSRC_IMM: rf_wdata = {{(DATA_W-FLD_W){1'b0}}, fld};
            default:  rf_wdata = alu_y;
        endcase
    end

    assign pc_out    = pc;
    assign fetch_out = (state == ST_FETCH);

    // R1: leaving Init the PC is zero
    a_r1_init_clears_pc: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INIT) |=> (pc == '0));

    // R2: fetch advances the PC by one
    a_r2_fetch_incr: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |=> (pc == $past(pc) + PC_W'(1)));

    // R2: the instruction register only changes on fetch
    a_r2_ir_hold: assert property (@(posedge clk) disable iff (rst)
        (state != ST_FETCH) |=> $stable(ir));

    // R6: a taken branch applies offset minus one
    a_r6_jump_taken: assert property (@(posedge clk) disable iff (rst)
        (state == ST_JZ && rp_data == '0) |=> (pc == $past(pc) + $past(jump_off) - PC_W'(1)));

    // R7: an untaken branch keeps the PC
    a_r7_jump_not_taken: assert property (@(posedge clk) disable iff (rst)
        (state == ST_JZ && rp_data != '0) |=> $stable(pc));

    // R8: an undefined opcode keeps the PC
    a_r8_idle_pc_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> $stable(pc));
endmodule

// File: tb/sim_proc6_core.sv
module sim_proc6_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic        ld_dmem = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [7:0]  peek_addr = '0;
    logic [15:0] peek_data;
    logic [15:0] pc_out;
    logic        fetch_out;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    proc6_core u0 (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data), .peek_addr(peek_addr),
        .peek_data(peek_data), .pc_out(pc_out), .fetch_out(fetch_out)
    );

    function automatic logic [15:0] enc(input logic [3:0] op, input logic [3:0] a,
                                        input logic [7:0] f);
        return {op, a, f};
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input bit to_d, input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_dmem = to_d; ld_addr = a; ld_data = d;
        @(posedge clk);
        #1 ld_en = 1'b0;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic peek(input logic [7:0] a, output logic [15:0] v);
        peek_addr = a;
        #1 v = peek_data;
    endtask

    task automatic t_reset_state();
        hold_reset();
        @(negedge clk);
        check(pc_out == 16'h0, "R1 pc in reset", pc_out, 16'h0);
        check(fetch_out == 1'b0, "R1 not fetching in reset", {15'h0, fetch_out}, 16'h0);
    endtask

    task automatic t_sum_timing();
        logic [15:0] v;
        hold_reset();
        wr(0, 0, enc(4'h0, 4'h0, 8'd0));
        wr(0, 1, enc(4'h0, 4'h1, 8'd1));
        wr(0, 2, 16'h2201);
        wr(0, 3, enc(4'h1, 4'h2, 8'd9));
        wr(0, 4, enc(4'h3, 4'hF, 8'd0));
        wr(0, 5, enc(4'h5, 4'hF, 8'd0));
        wr(1, 0, 16'd99);
        wr(1, 1, 16'd102);
        wr(1, 9, 16'hDEAD);
        release_reset();
        edges(1);
        check(fetch_out == 1'b1, "R1 fetch after release", {15'h0, fetch_out}, 16'h1);
        check(pc_out == 16'h0, "R1 first fetch address", pc_out, 16'h0);
        edges(1);
        check(pc_out == 16'h1, "R2 pc after fetch", pc_out, 16'h1);
        edges(10);
        peek(9, v);
        check(v == 16'hDEAD, "R2 store not before edge 13", v, 16'hDEAD);
        edges(1);
        peek(9, v);
        check(v == 16'd201, "R3 R4 sum stored on edge 13", v, 16'd201);
    endtask

    task automatic t_arith();
        logic [15:0] v;
        hold_reset();
        wr(0, 0,  enc(4'h3, 4'h1, 8'd5));
        wr(0, 1,  enc(4'h3, 4'h2, 8'd7));
        wr(0, 2,  16'h4312);
        wr(0, 3,  enc(4'h1, 4'h3, 8'd30));
        wr(0, 4,  16'h2421);
        wr(0, 5,  enc(4'h1, 4'h4, 8'd31));
        wr(0, 6,  enc(4'h3, 4'h5, 8'hF0));
        wr(0, 7,  enc(4'h1, 4'h5, 8'd32));
        wr(0, 8,  enc(4'h0, 4'h6, 8'd40));
        wr(0, 9,  16'h2762);
        wr(0, 10, enc(4'h1, 4'h7, 8'd33));
        wr(0, 11, enc(4'h3, 4'hF, 8'd0));
        wr(0, 12, enc(4'h5, 4'hF, 8'd0));
        wr(1, 40, 16'hFFFF);
        release_reset();
        edges(80);
        peek(30, v); check(v == 16'hFFFE, "R4 subtract wraps", v, 16'hFFFE);
        peek(31, v); check(v == 16'd12,   "R4 add", v, 16'd12);
        peek(32, v); check(v == 16'h00F0, "R5 constant zero-extended", v, 16'h00F0);
        peek(33, v); check(v == 16'h0006, "R3 R4 loaded word add wraps", v, 16'h0006);
    endtask

    task automatic t_count(input logic [15:0] a, input logic [15:0] b,
                           input logic [15:0] exp);
        logic [15:0] v;
        hold_reset();
        wr(0, 0,  enc(4'h3, 4'h0, 8'd0));
        wr(0, 1,  enc(4'h3, 4'h1, 8'd1));
        wr(0, 2,  enc(4'h0, 4'h2, 8'd4));
        wr(0, 3,  enc(4'h5, 4'h2, 8'd2));
        wr(0, 4,  16'h2001);
        wr(0, 5,  enc(4'h0, 4'h2, 8'd5));
        wr(0, 6,  enc(4'h5, 4'h2, 8'd2));
        wr(0, 7,  16'h2001);
        wr(0, 8,  enc(4'h1, 4'h0, 8'd9));
        wr(0, 9,  enc(4'h3, 4'hF, 8'd0));
        wr(0, 10, enc(4'h5, 4'hF, 8'd0));
        wr(1, 4, a);
        wr(1, 5, b);
        wr(1, 9, 16'hBEEF);
        release_reset();
        edges(60);
        peek(9, v);
        check(v == exp, "R6 R7 nonzero count via skips", v, exp);
        check(pc_out == 16'd10 || pc_out == 16'd11, "R6 self branch holds pc", pc_out, 16'd10);
    endtask

    task automatic t_loop();
        logic [15:0] v;
        hold_reset();
        wr(0, 0, enc(4'h3, 4'h0, 8'd0));
        wr(0, 1, enc(4'h3, 4'h1, 8'd3));
        wr(0, 2, enc(4'h3, 4'h2, 8'd1));
        wr(0, 3, enc(4'h3, 4'h3, 8'd0));
        wr(0, 4, 16'h2331);
        wr(0, 5, 16'h4112);
        wr(0, 6, enc(4'h5, 4'h1, 8'd2));
        wr(0, 7, enc(4'h5, 4'h0, 8'hFD));
        wr(0, 8, enc(4'h1, 4'h3, 8'd10));
        wr(0, 9, enc(4'h5, 4'h0, 8'd0));
        wr(1, 10, 16'h0);
        release_reset();
        edges(120);
        peek(10, v);
        check(v == 16'd6, "R6 backward branch loop sum", v, 16'd6);
    endtask

    task automatic t_undefined();
        logic [15:0] v;
        hold_reset();
        wr(0, 0, enc(4'h3, 4'h1, 8'd7));
        wr(0, 1, 16'h6100);
        wr(0, 2, 16'hF1FF);
        wr(0, 3, 16'h9114);
        wr(0, 4, enc(4'h1, 4'h1, 8'd20));
        wr(0, 5, enc(4'h3, 4'hF, 8'd0));
        wr(0, 6, enc(4'h5, 4'hF, 8'd0));
        wr(1, 0,   16'h1234);
        wr(1, 255, 16'h5678);
        wr(1, 20,  16'h0);
        release_reset();
        edges(60);
        peek(20, v);  check(v == 16'd7,    "R8 register untouched by undefined", v, 16'd7);
        peek(0, v);   check(v == 16'h1234, "R8 memory word 0 untouched", v, 16'h1234);
        peek(255, v); check(v == 16'h5678, "R8 memory word 255 untouched", v, 16'h5678);
    endtask

    task automatic t_preload_and_midreset();
        logic [15:0] v;
        wr(1, 77, 16'hA5C3);
        peek(77, v);
        check(v == 16'hA5C3, "R9 preload readable by peek", v, 16'hA5C3);
        @(negedge clk);
        rst = 1'b1;
        edges(1);
        check(pc_out == 16'h0, "R1 reset mid-run clears pc", pc_out, 16'h0);
        check(fetch_out == 1'b0, "R1 reset mid-run leaves fetch", {15'h0, fetch_out}, 16'h0);
        rst = 1'b0;
        edges(1);
        check(fetch_out == 1'b1, "R1 restart fetches", {15'h0, fetch_out}, 16'h1);
    endtask

    initial begin
        t_reset_state();
        t_sum_timing();
        t_arith();
        t_count(16'h0,  16'h3,  16'd1);
        t_count(16'h7,  16'h8,  16'd2);
        t_count(16'h0,  16'h0,  16'd0);
        t_loop();
        t_undefined();
        t_preload_and_midreset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule